// File: doc/BRIEF.md
# Reset Qualifier and Start-Vector Fetch Sequencer

This block is the bus front end of a small 8-bit processor. It runs from a power-up or a reset request up to the point where the first instruction can be fetched. A reset request comes in on an active-low input. The block treats it as real only when it has been sampled low on a minimum number of consecutive rising clock edges. A shorter glitch is ignored.

Once a qualified request is released, the block reads a two-byte start vector over its 16-bit address bus. Both reads are read cycles, and the valid-address strobe is high during each of them. The first byte read is the low half of the start address and the second byte is the high half. The block then loads these into the program counter.

A parameter picks one of two conventions. In the first, the vector sits at the top-minus-three and top-minus-two addresses and the reset must be held for 7 edges. In the second, the vector sits at the two topmost addresses and the reset must be held for 8 edges.

A separate asynchronous system reset puts the block into its initial state. When the load completes, a single-cycle flag is raised and the program counter is shown on an output port. The value on that port is held until the next load.

Top module: `resetVectorSeq`

## Requirements
- R1: When `rstN` has been sampled low on at least HOLD_MIN consecutive rising edges and is then sampled high, the first fetch cycle starts on the next cycle. HOLD_MIN is 7 with VARIANT=0 and 8 with VARIANT=1.
- R2: A low pulse on `rstN` that lasts fewer than HOLD_MIN edges is ignored. No fetch cycle follows, `pcLoaded` stays low and `pcOut` keeps its value.
- R3: The first fetch cycle drives address 16'hFFFC and the second drives 16'hFFFD when VARIANT=0. With VARIANT=1 the two cycles drive 16'hFFFE and then 16'hFFFF.
- R4: `rdWrN` is 1 (read) in every fetch cycle. The encoding is 1 for read and 0 for write.
- R5: `vma` is 1 in exactly the two fetch cycles. In all other cycles `vma` is 0 and `addrBus` is 0.
- R6: In the cycle after any rising edge that samples `rstN` low, `vma` is 0.
- R7: `dataIn` is sampled at the rising edge that ends each fetch cycle. The loaded program counter is {second byte, first byte}, so the bytes 8'hFF then 8'hA0 give 16'hA0FF.
- R8: `pcLoaded` is high for exactly the one cycle after the second fetch cycle, and `pcOut` carries the new value in that cycle. At all other times `pcOut` holds its value.
- R9: If `rstN` is sampled low at the end of either fetch cycle, the fetch is abandoned, the next cycle is idle and nothing is loaded. The hold count restarts from that edge.
- R10: While `sysRstN` is low, the block is idle: `pcOut` is 0, `vma` and `pcLoaded` are 0 and the hold count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRstN | input | 1 | Asynchronous system reset, active low |
| rstN | input | 1 | Processor reset request, active low, qualified by hold length |
| dataIn | input | 8 | Read data returned by memory for the current address |
| addrBus | output | 16 | Address bus, 0 when no fetch is in progress |
| rdWrN | output | 1 | Bus direction, 1 = read |
| vma | output | 1 | Valid memory address strobe |
| pcLoaded | output | 1 | One-cycle pulse when the program counter has been loaded |
| pcOut | output | 16 | Loaded program counter |

## Verification
The assertions assume that `rstN` and `dataIn` are stable around the rising edge. They also assume that `dataIn` is a combinational function of `addrBus` within the same cycle, as an asynchronous memory would return it.

The bench changes `rstN` and the stored vector bytes only on falling edges. It models the memory as a combinational lookup of the address.

Random pulse lengths on both sides of each variant's minimum are mixed with aborts in either fetch cycle. The same stimulus drives both variants side by side, so a 7-edge pulse separates their qualification rules.

// File: rtl/rvsPkg.sv
package rvsPkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FETCH_LO = 2'd1,
    ST_FETCH_HI = 2'd2,
    ST_DONE     = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic driveLo;
    logic driveHi;
    logic capLo;
    logic capHi;
    logic doneStb;
  } rvsStrobes_t;

endpackage

// File: rtl/rvsCtrl.sv
module rvsCtrl
  import rvsPkg::*;
#(
  parameter int HOLD_MIN = 7
) (
  input  logic        clk,
  input  logic        sysRstN,
  input  logic        rstN,
  output rvsStrobes_t stb
);
  localparam int CNT_W = $clog2(HOLD_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HOLD_MIN);

  seqState_t        state, stateNxt;
  logic [CNT_W-1:0] lowCnt;
  logic             qualified;

  assign qualified = (lowCnt == CNT_TOP);

  // consecutive-low counter, saturating at the minimum hold
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)       lowCnt <= '0;
    else if (!rstN) begin
      if (!qualified)   lowCnt <= lowCnt + 1'b1;
    end else            lowCnt <= '0;
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:     if (rstN && qualified) stateNxt = ST_FETCH_LO;
      ST_FETCH_LO: stateNxt = rstN ? ST_FETCH_HI : ST_IDLE;
      ST_FETCH_HI: stateNxt = rstN ? ST_DONE : ST_IDLE;
      ST_DONE:     stateNxt = ST_IDLE;
      default:     stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) state <= ST_IDLE;
    else          state <= stateNxt;
  end

  always_comb begin
    stb.driveLo = (state == ST_FETCH_LO);
    stb.driveHi = (state == ST_FETCH_HI);
    stb.capLo   = (state == ST_FETCH_LO) && rstN;
    stb.capHi   = (state == ST_FETCH_HI) && rstN;
    stb.doneStb = (state == ST_DONE);
  end

  // R1
  fetch_entry_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (state == ST_FETCH_LO) |-> ($past(qualified) && $past(rstN) && $past(state) == ST_IDLE));

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    $past(!rstN) |-> (state == ST_IDLE));

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    lowCnt <= CNT_TOP);

endmodule

// File: rtl/rvsDatapath.sv
module rvsDatapath
  import rvsPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_LO = '0,
  parameter logic [ADDR_W-1:0] VEC_HI = '0
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  rvsStrobes_t       stb,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addrBus,
  output logic              rdWrN,
  output logic              vma,
  output logic [ADDR_W-1:0] pcOut,
  output logic              pcLoaded
);
  logic [DATA_W-1:0] loByte;
  logic [ADDR_W-1:0] pcReg;

  always_comb begin
    addrBus = '0;
    if (stb.driveLo)      addrBus = VEC_LO;
    else if (stb.driveHi) addrBus = VEC_HI;
  end

  assign vma      = stb.driveLo | stb.driveHi;
  assign rdWrN    = 1'b1;
  assign pcLoaded = stb.doneStb;
  assign pcOut    = pcReg;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)       loByte <= '0;
    else if (stb.capLo) loByte <= dataIn;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)       pcReg <= '0;
    else if (stb.capHi) pcReg <= {dataIn, loByte};
  end

  // R5
  vma_addr_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    vma |-> (addrBus == VEC_LO || addrBus == VEC_HI));

  // R3
  addr_order_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (vma && addrBus == VEC_HI) |-> ($past(vma) && $past(addrBus) == VEC_LO));

endmodule

// File: rtl/resetVectorSeq.sv
module resetVectorSeq
  import rvsPkg::*;
#(
  parameter int VARIANT = 0,
  parameter int DATA_W  = 8
) (
  input  logic                clk,
  input  logic                sysRstN,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [2*DATA_W-1:0] addrBus,
  output logic                rdWrN,
  output logic                vma,
  output logic                pcLoaded,
  output logic [2*DATA_W-1:0] pcOut
);
  localparam int ADDR_W   = 2 * DATA_W;
  localparam int HOLD_MIN = (VARIANT == 0) ? 7 : 8;
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] VEC_LO   = (VARIANT == 0) ? TOP_ADDR - ADDR_W'(3)
                                                          : TOP_ADDR - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] VEC_HI   = VEC_LO + ADDR_W'(1);

  rvsStrobes_t stb;

  rvsCtrl #(.HOLD_MIN(HOLD_MIN)) i_ctrl (
    .clk(clk), .sysRstN(sysRstN), .rstN(rstN), .stb(stb)
  );

  rvsDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_LO(VEC_LO), .VEC_HI(VEC_HI)) i_dp (
    .clk(clk), .sysRstN(sysRstN), .stb(stb), .dataIn(dataIn),
    .addrBus(addrBus), .rdWrN(rdWrN), .vma(vma), .pcOut(pcOut), .pcLoaded(pcLoaded)
  );

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    pcLoaded |=> !pcLoaded);

  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    !pcLoaded |-> $stable(pcOut));

  // R6
  vma_quiet_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    $past(!rstN) |-> !vma);

  // R8
  done_after_fetch_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    pcLoaded |-> ($past(vma) && $past(addrBus) == VEC_HI));

endmodule

// File: tb/test_resetVectorSeq.sv
module test_resetVectorSeq;
  logic clk = 1'b0;
  logic sysRstN = 1'b0;
  logic rstN = 1'b1;
  logic [1:0][7:0]  dataA;
  logic [1:0][15:0] addrA;
  logic [1:0][15:0] pcA;
  logic [1:0]       rwA, vmaA, doneA;

  logic [7:0]  vecMem [4];
  logic [15:0] pcExp [2];
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  resetVectorSeq #(.VARIANT(0)) i_resetVectorSeq (
    .clk(clk), .sysRstN(sysRstN), .rstN(rstN), .dataIn(dataA[0]),
    .addrBus(addrA[0]), .rdWrN(rwA[0]), .vma(vmaA[0]), .pcLoaded(doneA[0]), .pcOut(pcA[0]));

  resetVectorSeq #(.VARIANT(1)) i_resetVectorSeqAlt (
    .clk(clk), .sysRstN(sysRstN), .rstN(rstN), .dataIn(dataA[1]),
    .addrBus(addrA[1]), .rdWrN(rwA[1]), .vma(vmaA[1]), .pcLoaded(doneA[1]), .pcOut(pcA[1]));

  function automatic logic [7:0] memRead(logic [15:0] a);
    if (a >= 16'hFFFC) return vecMem[a - 16'hFFFC];
    return 8'h5A;
  endfunction

  function automatic logic [15:0] vecLo(int i);
    return (i == 0) ? 16'hFFFC : 16'hFFFE;
  endfunction

  function automatic int holdOf(int i);
    return (i == 0) ? 7 : 8;
  endfunction

  function automatic logic [15:0] joinVec(int i);
    return (i == 0) ? {vecMem[1], vecMem[0]} : {vecMem[3], vecMem[2]};
  endfunction

  always_comb begin
    dataA[0] = memRead(addrA[0]);
    dataA[1] = memRead(addrA[1]);
  end

  task automatic check(string req, string what, int inst, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s inst%0d %s: got %h expected %h", req, inst, what, act, exp);
    end
  endtask

  // called at a falling edge; holds rstN low for n rising edges, then releases
  task automatic pulse(int n, int abortAt);
    rstN = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        check("R6", "vma while held", i, 32'(vmaA[i]), 0);
        check("R9", "done while held", i, 32'(doneA[i]), 0);
        check("R2", "pc while held", i, 32'(pcA[i]), 32'(pcExp[i]));
      end
    end
    rstN = 1'b1;
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        bit q;
        q = (n >= holdOf(i));
        check("R4", "rdWrN", i, 32'(rwA[i]), 1);
        if (c == 1) begin
          check(q ? "R1" : "R2", "vma cycle1", i, 32'(vmaA[i]), 32'(q));
          check("R3", "addr cycle1", i, 32'(addrA[i]), q ? 32'(vecLo(i)) : 0);
        end else if (c == 2) begin
          check("R5", "vma cycle2", i, 32'(vmaA[i]), 32'(q));
          check("R3", "addr cycle2", i, 32'(addrA[i]), q ? 32'(vecLo(i) + 16'd1) : 0);
        end else if (c == 3) begin
          check("R8", "done pulse", i, 32'(doneA[i]), 32'(q));
          check("R5", "vma after fetch", i, 32'(vmaA[i]), 0);
          if (q) pcExp[i] = joinVec(i);
        end else begin
          check("R8", "done clears", i, 32'(doneA[i]), 0);
          check("R5", "addr idle", i, 32'(addrA[i]), 0);
        end
        check(c == 3 ? "R7" : "R8", "pcOut", i, 32'(pcA[i]), 32'(pcExp[i]));
      end
      if (c == abortAt) begin
        rstN = 1'b0;
        return;
      end
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    for (int j = 0; j < 4; j++) vecMem[j] = 8'h00;
    pcExp[0] = '0;
    pcExp[1] = '0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      check("R10", "reset pc", i, 32'(pcA[i]), 0);
      check("R10", "reset vma", i, 32'(vmaA[i]), 0);
      check("R10", "reset done", i, 32'(doneA[i]), 0);
    end
    sysRstN = 1'b1;
    @(negedge clk);

    // example vector: low byte FF, high byte A0
    vecMem[0] = 8'hFF; vecMem[1] = 8'hA0; vecMem[2] = 8'h34; vecMem[3] = 8'h12;
    pulse(8, 0);          // R7: both load
    pulse(1, 0);          // R2: glitch
    pulse(6, 0);          // R2: one short of variant 0
    vecMem[0] = 8'h11; vecMem[1] = 8'h22; vecMem[2] = 8'h33; vecMem[3] = 8'h44;
    pulse(7, 0);          // R1: only variant 0 qualifies
    pulse(20, 0);         // R1: long hold
    vecMem[0] = 8'hC3; vecMem[1] = 8'h3C; vecMem[2] = 8'h96; vecMem[3] = 8'h69;
    pulse(9, 1);          // R9: abort in first fetch cycle
    pulse(6, 0);          // R9: count restarted, 6 edges do not qualify
    pulse(9, 2);          // R9: abort in second fetch cycle
    pulse(8, 0);          // both load after abort

    for (int it = 0; it < 60; it++) begin
      int n, ab;
      for (int j = 0; j < 4; j++) vecMem[j] = 8'($urandom);
      n  = 1 + int'($urandom % 11);
      ab = ($urandom % 5 == 0) ? 1 + int'($urandom % 2) : 0;
      pulse(n, ab);
      if (ab == 0) repeat (int'($urandom % 3)) @(negedge clk);
    end
    rstN = 1'b1;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule